// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

This block sits between ten interrupt request lines and a processor. Each line owns one vector, and the vector addresses run from 0x00003 upward in steps of 8, so the last one is 0x0004B. Each line also carries a one-bit tier select. The block chooses the most urgent eligible request and presents it to the processor as a registered request with a vector address and a level. It also keeps a small stack of the levels currently in service, so that nested interrupts follow strict preemption.

There are three levels: top, high and low. The two lowest vectors can be placed at top or at low. The other eight can be placed at high or at low. A pending request is eligible only when its level is strictly above the level now in service. Among the eligible requests, the highest level wins, and a tie goes to the lowest vector. The processor pulses an acknowledge to accept the presented request, which pushes that request's level onto the in-service stack. It pulses a return strobe when the handler finishes, which pops the stack.

Top module: `intarb_top`

## Requirements
- R1: After reset, int_req is 0, int_vec is 0 and act_lvl is 0 (nothing in service).
- R2: The address presented for line i is 0x00003 + 8*i on the 20-bit int_vec.
- R3: Level codes on int_lvl and act_lvl are 0 = none, 1 = low, 2 = high, 3 = top. When lvl_sel[i] is 1, line 0 or line 1 gets level 3 and any other line gets level 2. When lvl_sel[i] is 0, the line gets level 1.
- R4: When eligible requests of different levels are pending together, the one with the highest level is presented.
- R5: Among eligible requests that share the highest level, the one with the lowest line index is presented.
- R6: A request whose level is equal to or below act_lvl is held off. When act_lvl is 0, any request is eligible.
- R7: int_req rises on the clock edge after an eligible request is seen. While it stays high, int_vec and int_lvl do not change until an acknowledge arrives, even if other requests appear.
- R8: An acknowledge while int_req is high drops int_req on the next cycle and makes act_lvl equal to the acknowledged level.
- R9: A return strobe pops the in-service stack, so act_lvl goes back to the level that was under the popped one, or to 0. A return with an empty stack has no effect.
- R10: An acknowledge while int_req is low has no effect on act_lvl or on int_req.
- R11: An acknowledge and a return in the same cycle replace the top stack entry with the acknowledged level, and the depth stays the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 10 | Pending request per line, held by the source until it is acknowledged |
| lvl_sel | input | 10 | Tier select per line: 1 = upper tier allowed for that line, 0 = low |
| int_ack | input | 1 | Processor acknowledge strobe |
| int_ret | input | 1 | Return-from-interrupt strobe |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | 20 | Vector address of the presented request |
| int_lvl | output | 2 | Level of the presented request |
| act_lvl | output | 2 | Level on top of the in-service stack, 0 when empty |

## Verification
The assertions take for granted that a source keeps its request line high until the processor acknowledges it, and then drops it within the acknowledge cycle. They also assume the processor issues a return only for a handler it has entered. On that basis, the presented level is always above the level in service, and nested depth never passes three. The bench models the source by clearing the acknowledged line, which it decodes from the presented address, in the same cycle as the acknowledge. Its random phase does issue spare acknowledges and spare returns. These stay legal, because the block must ignore an acknowledge with no request and a return with an empty stack.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
  localparam logic [1:0] LV_NONE = 2'd0;
  localparam logic [1:0] LV_LOW  = 2'd1;
  localparam logic [1:0] LV_HIGH = 2'd2;
  localparam logic [1:0] LV_TOP  = 2'd3;
endpackage

// File: rtl/intarb_level_map.sv
module intarb_level_map
  import intarb_pkg::*;
#(
  parameter int N_VEC = 10,
  parameter int N_TOP = 2
) (
  input  logic [N_VEC-1:0]      lvl_sel,
  output logic [N_VEC-1:0][1:0] line_lvl
);
  for (genvar i = 0; i < N_VEC; i++) begin : g_line
    if (i < N_TOP) begin : g_top_tier
      assign line_lvl[i] = lvl_sel[i] ? LV_TOP : LV_LOW;
    end else begin : g_high_tier
      assign line_lvl[i] = lvl_sel[i] ? LV_HIGH : LV_LOW;
    end
  end
endmodule

// File: rtl/intarb_select.sv
module intarb_select #(
  parameter int N_VEC = 10,
  parameter int IDX_W = 4
) (
  input  logic [N_VEC-1:0]      req,
  input  logic [N_VEC-1:0][1:0] line_lvl,
  input  logic [1:0]            floor_lvl,
  output logic                  hit,
  output logic [IDX_W-1:0]      win_idx,
  output logic [1:0]            win_lvl
);
  logic [N_VEC-1:0] elig;

  for (genvar i = 0; i < N_VEC; i++) begin : g_elig
    assign elig[i] = req[i] && (line_lvl[i] > floor_lvl);
  end

  // scan from the highest index down; ">=" lets a lower index take a tie
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_lvl = 2'd0;
    for (int i = N_VEC - 1; i >= 0; i--) begin
      if (elig[i] && (line_lvl[i] >= win_lvl)) begin
        hit     = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = line_lvl[i];
      end
    end
  end
endmodule

// File: rtl/intarb_stack.sv
module intarb_stack #(
  parameter int DEPTH = 3,
  parameter int CNT_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  logic [1:0] din,
  output logic [1:0] top_lvl
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [DEPTH-1:0][1:0] mem_q, mem_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic                  en;

  always_comb begin
    mem_n = mem_q;
    cnt_n = cnt_q;
    if (push && pop && (cnt_q != '0)) begin
      mem_n[cnt_q - ONE] = din;
    end else if (push && (cnt_q < FULL)) begin
      mem_n[cnt_q] = din;
      cnt_n        = cnt_q + ONE;
    end else if (pop && (cnt_q != '0)) begin
      mem_n[cnt_q - ONE] = 2'd0;
      cnt_n              = cnt_q - ONE;
    end
  end

  assign en = push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      mem_q <= mem_n;
      cnt_q <= cnt_n;
    end
  end

  assign top_lvl = (cnt_q == '0) ? 2'd0 : mem_q[cnt_q - ONE];
endmodule

// File: rtl/intarb_top.sv
module intarb_top #(
  parameter int N_VEC    = 10,
  parameter int N_TOP    = 2,
  parameter int DEPTH    = 3,
  parameter int ADDR_W   = 20,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_VEC-1:0]  irq_in,
  input  logic [N_VEC-1:0]  lvl_sel,
  input  logic              int_ack,
  input  logic              int_ret,
  output logic              int_req,
  output logic [ADDR_W-1:0] int_vec,
  output logic [1:0]        int_lvl,
  output logic [1:0]        act_lvl
);
  localparam int IDX_W = (N_VEC > 1) ? $clog2(N_VEC) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [N_VEC-1:0][1:0] line_lvl;
  logic                  hit;
  logic [IDX_W-1:0]      win_idx;
  logic [1:0]            win_lvl;
  logic [1:0]            top_lvl;
  logic                  take;

  logic                  pres_q, pres_n;
  logic [ADDR_W-1:0]     addr_q, addr_n;
  logic [1:0]            lvl_q, lvl_n;
  logic                  load_en;

  intarb_level_map #(.N_VEC(N_VEC), .N_TOP(N_TOP)) u_map (
    .lvl_sel  (lvl_sel),
    .line_lvl (line_lvl)
  );

  intarb_select #(.N_VEC(N_VEC), .IDX_W(IDX_W)) u_sel (
    .req       (irq_in),
    .line_lvl  (line_lvl),
    .floor_lvl (top_lvl),
    .hit       (hit),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign take = pres_q & int_ack;

  intarb_stack #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (take),
    .pop     (int_ret),
    .din     (lvl_q),
    .top_lvl (top_lvl)
  );

  always_comb begin
    pres_n = pres_q;
    addr_n = addr_q;
    lvl_n  = lvl_q;
    if (pres_q) begin
      if (int_ack) pres_n = 1'b0;
    end else if (hit) begin
      pres_n = 1'b1;
      addr_n = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx);
      lvl_n  = win_lvl;
    end
  end

  assign load_en = take | (~pres_q & hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= 1'b0;
      addr_q <= '0;
      lvl_q  <= 2'd0;
    end else if (load_en) begin
      pres_q <= pres_n;
      addr_q <= addr_n;
      lvl_q  <= lvl_n;
    end
  end

  assign int_req = pres_q;
  assign int_vec = addr_q;
  assign int_lvl = lvl_q;
  assign act_lvl = top_lvl;
endmodule

// File: rtl/intarb_chk.sv
module intarb_chk #(
  parameter int N_VEC    = 10,
  parameter int N_TOP    = 2,
  parameter int ADDR_W   = 20,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_ack,
  input logic              int_ret,
  input logic              int_req,
  input logic [ADDR_W-1:0] int_vec,
  input logic [1:0]        int_lvl,
  input logic [1:0]        act_lvl
);
  localparam int LAST_ADDR = VEC_BASE + VEC_STEP * (N_VEC - 1);
  localparam int TOP_END   = VEC_BASE + VEC_STEP * N_TOP;

  AST_VEC_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((int'(int_vec) >= VEC_BASE) && (int'(int_vec) <= LAST_ADDR) &&
                 (((int'(int_vec) - VEC_BASE) % VEC_STEP) == 0))); // R2
  AST_TOP_TIER_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && (int_lvl == 2'd3)) |-> (int'(int_vec) < TOP_END)); // R3
  AST_HIGH_TIER_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && (int_lvl == 2'd2)) |-> (int'(int_vec) >= TOP_END)); // R3
  AST_STRICT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (int_lvl > act_lvl)); // R6
  AST_HOLD_TILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && !int_ack) |=> (int_req && $stable(int_vec) && $stable(int_lvl))); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack) |=> !int_req); // R8
  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_ack) |=> (act_lvl == $past(int_lvl))); // R8
  AST_EMPTY_RET: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_lvl == 2'd0) && int_ret && !(int_req && int_ack)) |=> (act_lvl == 2'd0)); // R9
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_req && int_ack && !int_ret) |=> $stable(act_lvl)); // R10
endmodule

bind intarb_top intarb_chk #(
  .N_VEC(N_VEC), .N_TOP(N_TOP), .ADDR_W(ADDR_W),
  .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .int_ret(int_ret),
  .int_req(int_req), .int_vec(int_vec), .int_lvl(int_lvl), .act_lvl(act_lvl)
);

// File: tb/sim_intarb_top.sv
module sim_intarb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  irq_in = '0;
  logic [9:0]  lvl_sel = '0;
  logic        int_ack = 1'b0;
  logic        int_ret = 1'b0;
  logic        int_req;
  logic [19:0] int_vec;
  logic [1:0]  int_lvl;
  logic [1:0]  act_lvl;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intarb_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_sel(lvl_sel),
    .int_ack(int_ack), .int_ret(int_ret), .int_req(int_req),
    .int_vec(int_vec), .int_lvl(int_lvl), .act_lvl(act_lvl)
  );

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model, behavioural
  int stk[$];
  bit m_pres;
  int m_vec, m_lvl;

  function automatic int line_level(int i, logic [9:0] s);
    if (!s[i]) return 1;
    return (i < 2) ? 3 : 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk.delete();
      m_pres = 0; m_vec = 0; m_lvl = 0;
    end else begin
      int top, best, bl;
      top = (stk.size() > 0) ? stk[stk.size()-1] : 0;
      best = -1; bl = 0;
      for (int i = 0; i < 10; i++)
        if (irq_in[i] && line_level(i, lvl_sel) > top && line_level(i, lvl_sel) > bl) begin
          bl = line_level(i, lvl_sel); best = i;
        end
      if (int_ack && m_pres) begin
        if (int_ret && stk.size() > 0) stk[stk.size()-1] = m_lvl;
        else stk.push_back(m_lvl);
      end else if (int_ret && stk.size() > 0) begin
        void'(stk.pop_back());
      end
      if (m_pres) begin
        if (int_ack) m_pres = 0;
      end else if (best >= 0) begin
        m_pres = 1; m_vec = 3 + 8 * best; m_lvl = bl;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      expect_eq("R7 model int_req", int'(int_req), int'(m_pres));
      expect_eq("R2 model int_vec", int'(int_vec), m_vec);
      expect_eq("R4 model int_lvl", int'(int_lvl), m_lvl);
      expect_eq("R9 model act_lvl", int'(act_lvl),
                (stk.size() > 0) ? stk[stk.size()-1] : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      done = 1'b1;
      bad++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    expect_eq("R1 reset int_req", int'(int_req), 0);
    expect_eq("R1 reset int_vec", int'(int_vec), 0);
    expect_eq("R1 reset act_lvl", int'(act_lvl), 0);

    // single low request on line 5
    irq_in[5] = 1'b1;
    cyc();
    expect_eq("R7 rise", int'(int_req), 1);
    expect_eq("R2 line5 addr", int'(int_vec), 'h2B);
    expect_eq("R3 low code", int'(int_lvl), 1);
    irq_in[0] = 1'b1;
    repeat (3) cyc();
    expect_eq("R7 hold vec", int'(int_vec), 'h2B);
    int_ack = 1'b1; irq_in[5] = 1'b0;
    cyc();
    int_ack = 1'b0;
    expect_eq("R8 drop", int'(int_req), 0);
    expect_eq("R8 push", int'(act_lvl), 1);
    repeat (2) cyc();
    expect_eq("R6 equal waits", int'(int_req), 0);
    int_ack = 1'b1;
    cyc();
    int_ack = 1'b0;
    cyc();
    expect_eq("R10 stray ack act", int'(act_lvl), 1);
    expect_eq("R10 stray ack req", int'(int_req), 0);
    lvl_sel[0] = 1'b1;
    cyc();
    expect_eq("R6 preempt", int'(int_req), 1);
    expect_eq("R2 line0 addr", int'(int_vec), 'h03);
    expect_eq("R3 top code", int'(int_lvl), 3);
    int_ack = 1'b1; irq_in[0] = 1'b0;
    cyc();
    int_ack = 1'b0;
    expect_eq("R8 nested push", int'(act_lvl), 3);
    int_ret = 1'b1;
    cyc();
    expect_eq("R9 pop", int'(act_lvl), 1);
    cyc();
    expect_eq("R9 pop2", int'(act_lvl), 0);
    cyc();
    int_ret = 1'b0;
    expect_eq("R9 empty ret", int'(act_lvl), 0);

    // priority and tie break
    lvl_sel = 10'b0010001000;
    irq_in = 10'b0010001010;
    cyc();
    expect_eq("R4 R5 pick", int'(int_vec), 'h1B);
    expect_eq("R3 high code", int'(int_lvl), 2);
    int_ack = 1'b1; irq_in[3] = 1'b0;
    cyc();
    int_ack = 1'b0;
    expect_eq("R8 high push", int'(act_lvl), 2);
    cyc();
    expect_eq("R6 high waits", int'(int_req), 0);
    lvl_sel[0] = 1'b1; irq_in[0] = 1'b1;
    cyc();
    expect_eq("R4 top over high", int'(int_vec), 'h03);
    int_ack = 1'b1; int_ret = 1'b1; irq_in[0] = 1'b0;
    cyc();
    int_ack = 1'b0; int_ret = 1'b0;
    expect_eq("R11 replace", int'(act_lvl), 3);
    cyc();
    expect_eq("R6 top blocks", int'(int_req), 0);
    int_ret = 1'b1;
    cyc();
    int_ret = 1'b0;
    expect_eq("R11 depth kept", int'(act_lvl), 0);
    cyc();
    expect_eq("R4 high over low", int'(int_vec), 'h3B);
    int_ack = 1'b1; irq_in[7] = 1'b0;
    cyc();
    int_ack = 1'b0;
    cyc();
    expect_eq("R6 low waits", int'(int_req), 0);
    int_ret = 1'b1;
    cyc();
    int_ret = 1'b0;
    cyc();
    expect_eq("R2 line1 addr", int'(int_vec), 'h0B);
    int_ack = 1'b1; irq_in[1] = 1'b0;
    cyc();
    int_ack = 1'b0; int_ret = 1'b1;
    cyc();
    int_ret = 1'b0;

    // random traffic, checked against the model each cycle
    for (int n = 0; n < 4000; n++) begin
      cyc();
      int_ack = 1'b0; int_ret = 1'b0;
      if (n % 250 == 0) lvl_sel = 10'($urandom);
      if ($urandom % 4 == 0) irq_in[$urandom % 10] = 1'b1;
      if (int_req && ($urandom % 3 == 0)) begin
        int_ack = 1'b1;
        irq_in[(int'(int_vec) - 3) / 8] = 1'b0;
      end else if ($urandom % 16 == 0) begin
        int_ack = 1'b1;
      end
      if ($urandom % 5 == 0) int_ret = 1'b1;
    end
    cyc();
    int_ack = 1'b0; int_ret = 1'b0;
    cyc();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule